// File: doc/BRIEF.md
# Register-Driven Serial Transmitter

This block sends asynchronous serial frames on a single output line. A host programs it through a small register port. It sets the character size, the number of stop bits, optional parity, and a 16-bit bit-time divisor held in two byte registers. It then writes a byte to the data register to start a frame. The frame is timed by a divisor-based bit timer. Each bit lasts `divisor × factor + 1` clock cycles. The factor is 16, or 8 when the double-speed bit is set.

Two status flags follow the frame. "Buffer empty" is clear while a frame is pending, and "frame done" is set when the last stop bit has finished. Each flag has its own interrupt enable. When a global interrupt enable input is high, a set flag with its enable on produces a one-cycle request pulse and clears itself.

The register port is a plain write strobe with a combinational read mux. Every write is accepted in the cycle it is presented, so there is no back-pressure. A data write is acted on only when the transmitter is enabled and idle. Otherwise the write is dropped.

Register map (3-bit address):
- 0: data. A write starts a frame. A read returns the last byte accepted.
- 1: control. Bit 0 is transmit enable, bit 1 is the empty interrupt enable, bit 2 is the done interrupt enable.
- 2: format. Bits 1:0 are the size code (0..3 means 5..8 data bits), bit 2 selects two stop bits, bit 3 turns parity on, bit 4 selects odd parity.
- 3: status. Bit 0 is empty, bit 1 is done, bit 2 is double speed. Only bit 2 is writable.
- 4: divisor low byte.
- 5: divisor high byte.

Top module: `sertx_top`

## Requirements
- R1: After reset, status reads 0x01 (only empty set), control reads 0x00, format reads 0x03 (8 data bits), both divisor bytes read 0, tx is high and both request outputs are low.
- R2: A frame is a low start bit, then the data bits LSB first (5 to 8 per size code), then the parity bit when format bit 3 is set, then one high stop bit, or two when format bit 2 is set. Parity is even (the XOR of the sent data bits) unless format bit 4 is set, which inverts it. The line is high when idle.
- R3: Each bit lasts `D × F + 1` cycles. D is `{divisor high, divisor low}`. F is 8 when status bit 2 is set and 16 otherwise.
- R4: An accepted data write clears both empty and done on the same edge. Both flags are set again exactly N × bit-time cycles later, where N is the frame's bit count.
- R5: A data write while control bit 0 is low is ignored: tx stays high and the status flags do not change.
- R6: Writing control with bit 0 set while it was clear sets the empty flag.
- R7: When the global enable is high and empty and control bit 1 are both set, irq_empty pulses high for one cycle on the next edge and the empty flag clears.
- R8: When the global enable is high and done and control bit 2 are both set, irq_done pulses high for one cycle on the next edge and the done flag clears.
- R9: While the global enable is low, no request pulses and the flags hold.
- R10: A data write while a frame is in progress is ignored. The current frame's bits and its end time are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gie | input | 1 | Global interrupt enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 8 | Read data (combinational) |
| tx | output | 1 | Serial output line |
| irq_empty | output | 1 | Buffer-empty request pulse |
| irq_done | output | 1 | Frame-done request pulse |

## Verification
A wrong frame image or bit index shows on tx at the centre of the bit it corrupts, so it appears within one bit time. A wrong bit-time length or bit count moves the cycle at which the status flags return. That is visible only at the end of the frame, as a flag edge one or more cycles early or late. A flag that fails to clear on service shows as a request held high for a second cycle, or as a status read that still shows the bit one cycle later.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
  localparam int DATA_W    = 8;
  localparam int ADDR_W    = 3;
  localparam int MAX_FRAME = 1 + DATA_W + 1 + 2;

  typedef enum logic [ADDR_W-1:0] {
    A_DATA = 3'd0,
    A_CTRL = 3'd1,
    A_FMT  = 3'd2,
    A_STAT = 3'd3,
    A_DIVL = 3'd4,
    A_DIVH = 3'd5
  } reg_addr_e;

  typedef struct packed {
    logic       par_odd;
    logic       par_on;
    logic       two_stop;
    logic [1:0] size;
  } fmt_t;

  localparam fmt_t FMT_RESET = '{par_odd: 1'b0, par_on: 1'b0, two_stop: 1'b0, size: 2'd3};
endpackage

// File: rtl/sertx_regs.sv
module sertx_regs
  import sertx_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gie,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              frame_end,
  input  logic              busy,
  output logic [DATA_W-1:0] rd_data,
  output logic              start,
  output logic [DATA_W-1:0] data_q,
  output fmt_t              fmt_q,
  output logic [DIV_W-1:0]  div_q,
  output logic              dbl_q,
  output logic              tx_en_q,
  output logic              st_empty,
  output logic              st_done,
  output logic              irq_empty,
  output logic              irq_done
);
  localparam int HI_W = DIV_W - 8;

  logic [7:0]      div_lo;
  logic [HI_W-1:0] div_hi;
  logic            ie_empty, ie_done;
  logic            wr_ctrl, txen_rise, serve_e, serve_d;
  logic            empty_nx, done_nx;

  assign div_q     = {div_hi, div_lo};
  assign wr_ctrl   = wr_en && (wr_addr == A_CTRL);
  assign txen_rise = wr_ctrl && wr_data[0] && !tx_en_q;
  assign start     = wr_en && (wr_addr == A_DATA) && tx_en_q && !busy;
  assign serve_e   = gie && st_empty && ie_empty;
  assign serve_d   = gie && st_done && ie_done;

  always_comb begin
    empty_nx = st_empty;
    done_nx  = st_done;
    if (serve_e)   empty_nx = 1'b0;
    if (serve_d)   done_nx  = 1'b0;
    if (txen_rise) empty_nx = 1'b1;
    if (frame_end) begin
      empty_nx = 1'b1;
      done_nx  = 1'b1;
    end
    if (start) begin
      empty_nx = 1'b0;
      done_nx  = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q    <= '0;
      fmt_q     <= FMT_RESET;
      div_lo    <= '0;
      div_hi    <= '0;
      dbl_q     <= 1'b0;
      tx_en_q   <= 1'b0;
      ie_empty  <= 1'b0;
      ie_done   <= 1'b0;
      st_empty  <= 1'b1;
      st_done   <= 1'b0;
      irq_empty <= 1'b0;
      irq_done  <= 1'b0;
    end else begin
      st_empty  <= empty_nx;
      st_done   <= done_nx;
      irq_empty <= serve_e;
      irq_done  <= serve_d;
      if (start) data_q <= wr_data;
      if (wr_ctrl) begin
        tx_en_q  <= wr_data[0];
        ie_empty <= wr_data[1];
        ie_done  <= wr_data[2];
      end
      if (wr_en && wr_addr == A_FMT)  fmt_q  <= fmt_t'(wr_data[4:0]);
      if (wr_en && wr_addr == A_STAT) dbl_q  <= wr_data[2];
      if (wr_en && wr_addr == A_DIVL) div_lo <= wr_data;
      if (wr_en && wr_addr == A_DIVH) div_hi <= wr_data[HI_W-1:0];
    end
  end

  always_comb begin
    case (rd_addr)
      A_DATA:  rd_data = data_q;
      A_CTRL:  rd_data = {5'b0, ie_done, ie_empty, tx_en_q};
      A_FMT:   rd_data = {3'b0, fmt_q};
      A_STAT:  rd_data = {5'b0, dbl_q, st_done, st_empty};
      A_DIVL:  rd_data = div_lo;
      A_DIVH:  rd_data = 8'(div_hi);
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/sertx_baud.sv
module sertx_baud #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  input  logic             dbl,
  output logic             tick
);
  localparam int CNT_W = DIV_W + 5;

  logic [CNT_W-1:0] len_q, cnt_q, len_nx;

  assign len_nx = (dbl ? (CNT_W'(div) << 3) : (CNT_W'(div) << 4)) + CNT_W'(1);
  assign tick   = run && (cnt_q == len_q - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      len_q <= CNT_W'(1);
      cnt_q <= '0;
    end else if (load) begin
      len_q <= len_nx;
      cnt_q <= '0;
    end else if (run) begin
      cnt_q <= tick ? '0 : cnt_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/sertx_shifter.sv
module sertx_shifter
  import sertx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] data,
  input  fmt_t              fmt,
  input  logic              tick,
  output logic              busy,
  output logic              tx,
  output logic              frame_end
);
  localparam int IDX_W = $clog2(MAX_FRAME + 1);

  logic [MAX_FRAME-1:0] frame_nx, frame_q;
  logic [IDX_W-1:0]     nbits_nx, nbits_q, idx_q;
  logic                 par;
  int                   nd;

  always_comb begin
    nd       = 5 + int'(fmt.size);
    frame_nx = '1;
    frame_nx[0] = 1'b0;
    par      = fmt.par_odd;
    for (int i = 0; i < DATA_W; i++) begin
      if (i < nd) begin
        frame_nx[1+i] = data[i];
        par           = par ^ data[i];
      end
    end
    if (fmt.par_on) frame_nx[1+nd] = par;
    nbits_nx = IDX_W'(1 + nd + (fmt.par_on ? 1 : 0) + (fmt.two_stop ? 2 : 1));
  end

  assign frame_end = busy && tick && (idx_q == nbits_q - IDX_W'(1));
  assign tx        = busy ? frame_q[idx_q] : 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      frame_q <= '1;
      nbits_q <= '0;
      idx_q   <= '0;
    end else if (load) begin
      busy    <= 1'b1;
      frame_q <= frame_nx;
      nbits_q <= nbits_nx;
      idx_q   <= '0;
    end else if (frame_end) begin
      busy  <= 1'b0;
      idx_q <= '0;
    end else if (busy && tick) begin
      idx_q <= idx_q + IDX_W'(1);
    end
  end
endmodule

// File: rtl/sertx_top.sv
module sertx_top
  import sertx_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gie,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              tx,
  output logic              irq_empty,
  output logic              irq_done
);
  logic              start, busy, tick, frame_end;
  logic              dbl_q, tx_en_q, st_empty, st_done;
  logic [DATA_W-1:0] data_q;
  logic [DIV_W-1:0]  div_q;
  fmt_t              fmt_q;

  sertx_regs #(.DIV_W(DIV_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .gie(gie), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .frame_end(frame_end), .busy(busy),
    .rd_data(rd_data), .start(start), .data_q(data_q), .fmt_q(fmt_q),
    .div_q(div_q), .dbl_q(dbl_q), .tx_en_q(tx_en_q), .st_empty(st_empty),
    .st_done(st_done), .irq_empty(irq_empty), .irq_done(irq_done)
  );

  sertx_baud #(.DIV_W(DIV_W)) u_baud (
    .clk(clk), .rst_n(rst_n), .load(start), .run(busy),
    .div(div_q), .dbl(dbl_q), .tick(tick)
  );

  sertx_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .load(start), .data(wr_data), .fmt(fmt_q),
    .tick(tick), .busy(busy), .tx(tx), .frame_end(frame_end)
  );
endmodule

// File: rtl/sertx_checker.sv
module sertx_checker
  import sertx_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              gie,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              tx,
  input logic              irq_empty,
  input logic              irq_done,
  input logic              busy,
  input logic              tx_en_q,
  input logic              st_empty,
  input logic              st_done
);
  logic data_wr;
  assign data_wr = wr_en && (wr_addr == A_DATA);

  // R2: once a frame is reported done the line is idle high
  a_r2_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    st_done |-> tx);

  // R4: an accepted data write clears both flags
  a_r4_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && tx_en_q && !busy) |=> (!st_empty && !st_done));

  // R5: a data write with transmit disabled leaves an idle line idle
  a_r5_disabled_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && !tx_en_q && !busy) |=> tx);

  // R6: enabling the transmitter marks the buffer empty
  a_r6_enable_sets_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_CTRL && wr_data[0] && !tx_en_q) |=> st_empty);

  // R7: empty request is one cycle long and leaves the flag clear
  a_r7_empty_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    irq_empty |=> !irq_empty);
  a_r7_empty_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    irq_empty |-> !st_empty);

  // R8: done request is one cycle long and leaves the flag clear
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    irq_done |=> !irq_done);
  a_r8_done_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    irq_done |-> !st_done);

  // R9: no request without the global enable
  a_r9_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(gie) |-> (!irq_empty && !irq_done));
endmodule

bind sertx_top sertx_checker u_chk (
  .clk(clk), .rst_n(rst_n), .gie(gie), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .tx(tx), .irq_empty(irq_empty), .irq_done(irq_done),
  .busy(busy), .tx_en_q(tx_en_q), .st_empty(st_empty), .st_done(st_done)
);

// File: tb/sertx_top_test.sv
module sertx_top_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       gie = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       tx, irq_empty, irq_done;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  sertx_top uut (
    .clk(clk), .rst_n(rst_n), .gie(gie), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .tx(tx),
    .irq_empty(irq_empty), .irq_done(irq_done)
  );

  // {fmt, data, div_lo, div_hi, dbl}
  localparam int NV = 6;
  localparam logic [32:0] VEC [NV] = '{
    {8'h03, 8'hA5, 8'h00, 8'h00, 1'b1},
    {8'h00, 8'h1F, 8'h01, 8'h00, 1'b0},
    {8'h0B, 8'h37, 8'h00, 8'h00, 1'b1},
    {8'h1F, 8'h80, 8'h02, 8'h00, 1'b1},
    {8'h0E, 8'hC3, 8'h00, 8'h00, 1'b0},
    {8'h13, 8'h5A, 8'h00, 8'h01, 1'b1}
  };

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rdreg(input logic [2:0] a, output logic [7:0] v);
    rd_addr = a;
    #1;
    v = rd_data;
  endtask

  function automatic int frame_len(input logic [7:0] f);
    return 1 + 5 + int'(f[1:0]) + (f[3] ? 1 : 0) + (f[2] ? 2 : 1);
  endfunction

  function automatic logic frame_bit(input logic [7:0] f, input logic [7:0] d, input int i);
    int nd;
    logic p;
    nd = 5 + int'(f[1:0]);
    p = f[4];
    for (int k = 0; k < nd; k++) p = p ^ d[k];
    if (i == 0) return 1'b0;
    if (i <= nd) return d[i-1];
    if (f[3] && i == nd + 1) return p;
    return 1'b1;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rdreg(3'd3, v); check("R1 status", v, 8'h01);
    rdreg(3'd1, v); check("R1 control", v, 8'h00);
    rdreg(3'd2, v); check("R1 format", v, 8'h03);
    rdreg(3'd4, v); check("R1 div lo", v, 0);
    rdreg(3'd5, v); check("R1 div hi", v, 0);
    check("R1 tx idle", tx, 1);
    check("R1 irqs low", {irq_empty, irq_done}, 0);

    // R5 data write with transmitter disabled
    @(negedge clk);
    wr(3'd0, 8'h55);
    for (int c = 0; c < 10; c++) begin
      check("R5 tx stays idle", tx, 1);
      @(negedge clk);
    end
    rdreg(3'd3, v); check("R5 status unchanged", v, 8'h01);

    // Vector table: R2 frame shape, R3 bit time, R4 flag timing
    @(negedge clk);
    wr(3'd1, 8'h01);
    for (int n = 0; n < NV; n++) begin
      logic [7:0] f, d, lo, hi;
      logic db;
      int L, N, pos, tgt;
      {f, d, lo, hi, db} = VEC[n];
      wr(3'd2, f);
      wr(3'd4, lo);
      wr(3'd5, hi);
      wr(3'd3, {5'b0, db, 2'b0});
      rdreg(3'd5, v); check("R3 div hi readback", v, hi);
      @(negedge clk);
      L = ({hi, lo} * (db ? 8 : 16)) + 1;
      N = frame_len(f);
      wr(3'd0, d);
      rdreg(3'd3, v); check("R4 flags cleared on write", v[1:0], 0);
      pos = 0;
      for (int i = 0; i < N; i++) begin
        tgt = i * L + L / 2;
        repeat (tgt - pos) @(negedge clk);
        pos = tgt;
        check($sformatf("R2 R3 vec%0d bit%0d", n, i), tx, frame_bit(f, d, i));
      end
      tgt = N * L - 1;
      repeat (tgt - pos) @(negedge clk);
      rdreg(3'd3, v); check("R4 done not yet", v[1:0], 0);
      @(negedge clk);
      rdreg(3'd3, v); check("R4 flags set at frame end", v[1:0], 2'b11);
      check("R2 idle after frame", tx, 1);
      @(negedge clk);
    end

    // R10 write during frame, R6 enable edge during frame
    begin
      int pos;
      wr(3'd2, 8'h03);
      wr(3'd4, 8'h01);
      wr(3'd5, 8'h00);
      wr(3'd3, 8'h00);
      wr(3'd0, 8'h01);          // L = 17, N = 10
      pos = 0;
      repeat (20) @(negedge clk); pos = 20;
      wr(3'd0, 8'hFE); pos = 21;
      repeat (4) @(negedge clk); pos = 25;
      check("R10 bit0 keeps first byte", tx, 1);
      repeat (5) @(negedge clk); pos = 30;
      wr(3'd1, 8'h00); pos = 31;
      wr(3'd1, 8'h01); pos = 32;
      rdreg(3'd3, v); check("R6 enable edge sets empty", v[1:0], 2'b01);
      repeat (169 - pos) @(negedge clk);
      rdreg(3'd3, v); check("R10 end time unchanged (before)", v[1], 0);
      @(negedge clk);
      rdreg(3'd3, v); check("R10 end time unchanged (at)", v[1], 1);
      rdreg(3'd0, v); check("R10 data reg holds first byte", v, 8'h01);
    end

    // R9 gated requests
    wr(3'd1, 8'h07);
    for (int c = 0; c < 4; c++) begin
      check("R9 no request while gated", {irq_empty, irq_done}, 0);
      @(negedge clk);
    end
    rdreg(3'd3, v); check("R9 flags held", v[1:0], 2'b11);

    // R7 empty request
    wr(3'd1, 8'h03);
    gie = 1'b1;
    @(negedge clk);
    check("R7 empty pulse", irq_empty, 1);
    check("R7 no done pulse", irq_done, 0);
    rdreg(3'd3, v); check("R7 empty cleared, done kept", v[1:0], 2'b10);
    @(negedge clk);
    check("R7 pulse one cycle", irq_empty, 0);

    // R8 done request
    wr(3'd1, 8'h05);
    check("R8 no pulse yet", irq_done, 0);
    @(negedge clk);
    check("R8 done pulse", irq_done, 1);
    rdreg(3'd3, v); check("R8 done cleared", v[1:0], 2'b00);
    @(negedge clk);
    check("R8 pulse one cycle", irq_done, 0);
    check("R8 no empty pulse", irq_empty, 0);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule